// File: doc/BRIEF.md
# CAN Bit Timing and Synchronisation Unit

This block turns a fast system clock into the bit rhythm of a CAN node. A prescaler cuts the clock into time quanta. A segment sequencer strings those quanta into a bit made of a single sync quantum, a span that covers bus delay plus the first phase segment, and a second phase segment. At the end of the first span the block samples the receive line. It reports the sampled value together with a one-cycle sample strobe. At the start of every bit it raises a one-cycle transmit-point strobe, and the framing logic uses that strobe to present its next bit.

The block follows the bus edges in two ways. While the framing logic reports the bus as idle, any falling edge restarts the bit at once (hard synchronisation). Once a frame is under way, a falling edge moves the bit boundary by at most the jump width, and only when this node is not itself sending a dominant bit. Only one synchronisation is taken between two sample points. An edge only counts when the last sampled bit was recessive. In the optional triple-sample mode the bit value is the majority of three samples spaced one quantum apart.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2*(brp_i+1) clock cycles, with brp_i a 6-bit value from 0 to 63.
- R2: With no synchronisation, a bit lasts 1+(prop_i+1)+(ph1_i+1)+(ph2_i+1) quanta. prop_i, ph1_i and ph2_i are each 3-bit fields that hold the segment length minus one. sample_o rises 1+(prop_i+1)+(ph1_i+1) quanta after txpt_o rises.
- R3: A ph2_i value of 0 is treated as a second phase segment of 2 quanta.
- R4: A falling edge is a cycle in which rx_i is 0 and was 1 in the cycle before. While idle_i is 1, a falling edge restarts the bit in that cycle, and txpt_o is high in the following cycle.
- R5: While idle_i is 0, a falling edge seen in quantum k (counted from 1) after the sync quantum, before the sample point, lengthens the first span by min(k, sjw_i+1) quanta. sjw_i is 2 bits.
- R6: While idle_i is 0, a falling edge seen in the second phase segment with r quanta left (the current quantum included) does one of two things. If r <= sjw_i+1, the bit ends at once and txpt_o is high in the following cycle. Otherwise the segment is shortened by sjw_i+1 quanta.
- R7: While idle_i is 0 and tx_dom_i is 1, falling edges cause no resynchronisation.
- R8: At most one synchronisation, hard or resync, is taken between two consecutive sample points. Later edges in that interval are ignored.
- R9: Falling edges are ignored while bit_o (the last sampled bit) is 0 (dominant).
- R10: With triple_i at 0, bit_o takes rx_i at the sample point. With triple_i at 1, bit_o takes the majority of rx_i at the sample point and at the two quantum boundaries before it. bit_o changes only in the cycle in which sample_o is high.
- R11: After reset sample_o and txpt_o are 0 and bit_o is 1. Each strobe is high for one cycle at a time, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Synchronised receive line, 1 = recessive |
| tx_dom_i | input | 1 | Node is currently driving a dominant bit |
| idle_i | input | 1 | Bus idle, start of frame expected (hard sync allowed) |
| brp_i | input | 6 | Quantum prescaler value |
| prop_i | input | 3 | Propagation segment length minus one |
| ph1_i | input | 3 | Phase segment 1 length minus one |
| ph2_i | input | 3 | Phase segment 2 length minus one (0 read as 1) |
| sjw_i | input | 2 | Resync jump width minus one |
| triple_i | input | 1 | Select three-sample majority vote |
| sample_o | output | 1 | One-cycle strobe at the sample point |
| bit_o | output | 1 | Value sampled at the last sample point |
| txpt_o | output | 1 | One-cycle strobe at the start of each bit |

## Verification
The hardest cases to reach from the ports are edges that land in one chosen quantum of one chosen segment. Examples are an edge in the last quantum before the sample point, which should clip at the jump width, and an edge with few enough quanta left in phase 2 to end the bit at once. The bench restarts from reset for each case and times the bit from the transmit-point strobe. It then drops rx_i on the exact cycle that places the edge in the target quantum, and compares the arrival cycles of the following strobes with lengths worked out by hand. Blocked edges use the same method: an edge inside a bit that has already synchronised, and an edge after a dominant sample, must leave the next strobe at its nominal cycle.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/can_bt_tq_gen.sv
module can_bt_tq_gen #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [BRP_W-1:0] brp,
  output logic             tick
);
  localparam int PC_W = BRP_W + 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] lim;

  assign lim  = {brp, 1'b1};
  assign tick = (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (tick)      pcnt <= '0;
    else                pcnt <= pcnt + PC_W'(1);
  end
endmodule

// File: rtl/can_bt_edge_det.sv
module can_bt_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic rx,
  output logic fall
);
  logic rx_prev;

  always_ff @(posedge clk) begin
    if (rst) rx_prev <= 1'b1;
    else     rx_prev <= rx;
  end

  assign fall = rx_prev & ~rx;
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler #(
  parameter int HIST = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sample_now,
  input  logic triple,
  input  logic rx,
  output logic bit_val
);
  import can_bt_pkg::*;

  logic [HIST-1:0] hist;
  logic            voted;

  assign voted = triple ? maj3(hist[HIST-1], hist[HIST-2], rx) : rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '1;
      bit_val <= 1'b1;
    end else begin
      if (tick)       hist    <= {hist[HIST-2:0], rx};
      if (sample_now) bit_val <= voted;
    end
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq #(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             fall,
  input  logic             idle,
  input  logic             tx_dom,
  input  logic             bit_rec,
  input  logic [SEG_W-1:0] prop,
  input  logic [SEG_W-1:0] ph1,
  input  logic [SEG_W-1:0] ph2,
  input  logic [SJW_W-1:0] sjw,
  output logic             sample_now,
  output logic             sync_start,
  output logic             restart,
  output logic             used
);
  import can_bt_pkg::*;

  localparam int MAX_Q = 2 * (1 << SEG_W) + (1 << SJW_W) + 1;
  localparam int CNT_W = $clog2(MAX_Q + 1);

  seg_e             seg;
  logic [CNT_W-1:0] qcnt;
  logic [CNT_W-1:0] ext_r, cut_r;

  logic [SEG_W-1:0] ph2_eff;
  logic [CNT_W-1:0] ts1_len, ts2_len, sjw_len;
  logic [CNT_W-1:0] e_late, ext_new, ext_now, ts1_end;
  logic [CNT_W-1:0] e_early, cut_now, ts2_end;
  logic             edge_ok, hs, rs, rs_late, rs_early, early_restart, bit_end;

  assign ph2_eff = (ph2 == '0) ? SEG_W'(1) : ph2;
  assign ts1_len = CNT_W'(prop) + CNT_W'(ph1) + CNT_W'(2);
  assign ts2_len = CNT_W'(ph2_eff) + CNT_W'(1);
  assign sjw_len = CNT_W'(sjw) + CNT_W'(1);

  assign edge_ok  = fall & bit_rec & ~used;
  assign hs       = edge_ok & idle;
  assign rs       = edge_ok & ~idle & ~tx_dom;
  assign rs_late  = rs & (seg == SEG_TS1);
  assign rs_early = rs & (seg == SEG_TS2);

  assign e_late  = qcnt + CNT_W'(1);
  assign ext_new = (e_late < sjw_len) ? e_late : sjw_len;
  assign ext_now = rs_late ? ext_new : ext_r;
  assign ts1_end = ts1_len + ext_now - CNT_W'(1);

  assign e_early       = ts2_len - qcnt;
  assign early_restart = rs_early & (e_early <= sjw_len);
  assign cut_now       = (rs_early & ~early_restart) ? sjw_len : cut_r;
  assign ts2_end       = ts2_len - cut_now - CNT_W'(1);

  assign restart    = hs | early_restart;
  assign sample_now = ~restart & tick & (seg == SEG_TS1) & (qcnt == ts1_end);
  assign bit_end    = ~restart & tick & (seg == SEG_TS2) & (qcnt == ts2_end);
  assign sync_start = restart | bit_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg   <= SEG_SYNC;
      qcnt  <= '0;
      ext_r <= '0;
      cut_r <= '0;
      used  <= 1'b0;
    end else if (restart) begin
      seg   <= SEG_SYNC;
      qcnt  <= '0;
      ext_r <= '0;
      cut_r <= '0;
      used  <= 1'b1;
    end else begin
      if (sample_now) used <= 1'b0;
      else if (rs)    used <= 1'b1;
      ext_r <= ext_now;
      cut_r <= cut_now;
      if (tick) begin
        unique case (seg)
          SEG_SYNC: begin
            seg  <= SEG_TS1;
            qcnt <= '0;
          end
          SEG_TS1: begin
            if (qcnt == ts1_end) begin
              seg  <= SEG_TS2;
              qcnt <= '0;
            end else begin
              qcnt <= qcnt + CNT_W'(1);
            end
          end
          default: begin
            if (bit_end) begin
              seg   <= SEG_SYNC;
              qcnt  <= '0;
              ext_r <= '0;
              cut_r <= '0;
            end else begin
              qcnt <= qcnt + CNT_W'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             tx_dom_i,
  input  logic             idle_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [SEG_W-1:0] prop_i,
  input  logic [SEG_W-1:0] ph1_i,
  input  logic [SEG_W-1:0] ph2_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic             triple_i,
  output logic             sample_o,
  output logic             bit_o,
  output logic             txpt_o
);
  logic tick, fall, restart, sample_now, sync_start, sync_used;

  can_bt_tq_gen #(.BRP_W(BRP_W)) u_tq (
    .clk(clk), .rst(rst), .restart(restart), .brp(brp_i), .tick(tick)
  );

  can_bt_edge_det u_edge (
    .clk(clk), .rst(rst), .rx(rx_i), .fall(fall)
  );

  can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .fall(fall), .idle(idle_i),
    .tx_dom(tx_dom_i), .bit_rec(bit_o), .prop(prop_i), .ph1(ph1_i),
    .ph2(ph2_i), .sjw(sjw_i), .sample_now(sample_now),
    .sync_start(sync_start), .restart(restart), .used(sync_used)
  );

  can_bt_sampler #(.HIST(2)) u_smp (
    .clk(clk), .rst(rst), .tick(tick), .sample_now(sample_now),
    .triple(triple_i), .rx(rx_i), .bit_val(bit_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= 1'b0;
      txpt_o   <= 1'b0;
    end else begin
      sample_o <= sample_now;
      txpt_o   <= sync_start;
    end
  end
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
  input logic clk,
  input logic rst,
  input logic rx_i,
  input logic idle_i,
  input logic tx_dom_i,
  input logic bit_o,
  input logic sample_o,
  input logic txpt_o,
  input logic sync_used
);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(sample_o && txpt_o));

  p_sample_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> !sample_o);

  p_txpt_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    txpt_o |=> !txpt_o);

  p_bit_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !sample_o |-> (bit_o == $past(bit_o)));

  p_hard_sync_r4: assert property (@(posedge clk) disable iff (rst)
    (idle_i && $fell(rx_i) && bit_o && !sync_used) |=> txpt_o);

  p_tx_block_r7: assert property (@(posedge clk) disable iff (rst)
    (!idle_i && tx_dom_i && $fell(rx_i) && bit_o && !sync_used) |=> !sync_used);
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
  .clk(clk), .rst(rst), .rx_i(rx_i), .idle_i(idle_i), .tx_dom_i(tx_dom_i),
  .bit_o(bit_o), .sample_o(sample_o), .txpt_o(txpt_o), .sync_used(sync_used)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1, tx_dom = 1'b0, idle = 1'b0, triple = 1'b0;
  logic [5:0] brp = '0;
  logic [2:0] prop = '0, ph1 = '0, ph2 = '0;
  logic [1:0] sjw = '0;
  logic sample_o, bit_o, txpt_o;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timing u_dut (
    .clk(clk), .rst(rst), .rx_i(rx), .tx_dom_i(tx_dom), .idle_i(idle),
    .brp_i(brp), .prop_i(prop), .ph1_i(ph1), .ph2_i(ph2), .sjw_i(sjw),
    .triple_i(triple), .sample_o(sample_o), .bit_o(bit_o), .txpt_o(txpt_o)
  );

  // brp, prop, ph1, ph2, expected txpt->sample cycles, expected bit period
  localparam logic [46:0] VEC [5] = '{
    {6'd0,  3'd0, 3'd1, 3'd2, 16'd8,   16'd14},
    {6'd1,  3'd2, 3'd3, 3'd1, 16'd32,  16'd40},
    {6'd3,  3'd7, 3'd7, 3'd7, 16'd136, 16'd200},
    {6'd0,  3'd0, 3'd0, 3'd0, 16'd6,   16'd10},   // R3: ph2 field 0 -> 2 quanta
    {6'd63, 3'd0, 3'd0, 3'd1, 16'd384, 16'd640}   // R1: largest prescaler
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_txpt(output int t);
    @(negedge clk);
    while (!txpt_o) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_sample(output int t);
    @(negedge clk);
    while (!sample_o) @(negedge clk);
    t = cyc;
  endtask

  task automatic at_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic cfg_a();
    brp = 6'd0; prop = 3'd0; ph1 = 3'd1; ph2 = 3'd2; sjw = 2'd1;
    rx = 1'b1; tx_dom = 1'b0; idle = 1'b0; triple = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int t0, t1, ts;
    // R11 reset state
    cfg_a();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset sample_o", int'(sample_o), 0);
    chk("R11 reset txpt_o", int'(txpt_o), 0);
    chk("R11 reset bit_o", int'(bit_o), 1);
    rst = 1'b0;

    // R1 R2 R3: nominal bit timing per table entry
    for (int i = 0; i < 5; i++) begin
      cfg_a();
      {brp, prop, ph1, ph2} = VEC[i][46:32];
      do_reset();
      wait_txpt(t0);
      wait_sample(ts);
      wait_txpt(t1);
      chk($sformatf("R1 R2 R3 vec %0d sample offset", i), ts - t0, int'(VEC[i][31:16]));
      chk($sformatf("R1 R2 R3 vec %0d bit period", i), t1 - t0, int'(VEC[i][15:0]));
    end

    // Config A: Q=2, first span 3q, phase 2 3q, jump width 2q
    // R5 late edge in first quantum: lengthen by 1
    cfg_a(); do_reset(); wait_txpt(t0);
    at_cyc(t0 + 2); rx = 1'b0;
    wait_sample(ts);
    chk("R5 late k=1 sample", ts - t0, 10);
    chk("R5 late k=1 bit", int'(bit_o), 0);

    // R5 late edge in third quantum: clipped at jump width 2
    cfg_a(); do_reset(); wait_txpt(t0);
    at_cyc(t0 + 6); rx = 1'b0;
    wait_sample(ts);
    chk("R5 late k=3 sample", ts - t0, 12);
    wait_txpt(t1);
    chk("R5 late k=3 period", t1 - t0, 18);

    // R7 same edge while sending dominant: no change
    cfg_a(); tx_dom = 1'b1; do_reset(); wait_txpt(t0);
    at_cyc(t0 + 2); rx = 1'b0;
    wait_sample(ts);
    chk("R7 tx dominant sample", ts - t0, 8);

    // R6 early edge with 1 quantum left: bit ends at once
    cfg_a(); do_reset(); wait_txpt(t0);
    at_cyc(t0 + 12); rx = 1'b0;
    wait_txpt(t1);
    chk("R6 early restart txpt", t1 - t0, 13);

    // R6 early edge with 3 quanta left: phase 2 cut by 2
    cfg_a(); do_reset(); wait_txpt(t0);
    at_cyc(t0 + 8); rx = 1'b0;
    wait_txpt(t1);
    chk("R6 early cut txpt", t1 - t0, 10);

    // R4 hard sync while idle, then R8 and R9 blocked edges
    cfg_a(); idle = 1'b1; do_reset(); wait_txpt(t0);
    at_cyc(t0 + 10); rx = 1'b0;
    wait_txpt(t1);
    chk("R4 hard sync txpt", t1 - t0, 11);
    at_cyc(t0 + 12); rx = 1'b1;
    at_cyc(t0 + 13); rx = 1'b0;
    wait_sample(ts);
    chk("R8 second edge ignored sample", ts - t0, 19);
    chk("R8 sampled bit", int'(bit_o), 0);
    at_cyc(t0 + 20); rx = 1'b1;
    at_cyc(t0 + 21); rx = 1'b0;
    wait_txpt(t1);
    chk("R9 edge after dominant ignored", t1 - t0, 25);

    // R10 triple sampling (tx_dom=1 keeps edges from resyncing)
    cfg_a(); tx_dom = 1'b1; triple = 1'b1; do_reset(); wait_txpt(t0);
    at_cyc(t0 + 7); rx = 1'b0;
    at_cyc(t0 + 8); rx = 1'b1;
    chk("R10 triple strobe", int'(sample_o), 1);
    chk("R10 triple one low of three", int'(bit_o), 1);

    cfg_a(); tx_dom = 1'b1; triple = 1'b0; do_reset(); wait_txpt(t0);
    at_cyc(t0 + 7); rx = 1'b0;
    at_cyc(t0 + 8); rx = 1'b1;
    chk("R10 single strobe", int'(sample_o), 1);
    chk("R10 single sample low", int'(bit_o), 0);

    cfg_a(); tx_dom = 1'b1; triple = 1'b1; do_reset(); wait_txpt(t0);
    at_cyc(t0 + 5); rx = 1'b0;
    at_cyc(t0 + 8); rx = 1'b1;
    chk("R10 triple two low of three", int'(bit_o), 0);

    summary();
    $finish;
  end
endmodule